// File: doc/BRIEF.md
# PTP Receive Timestamp Snapshot FIFO

This block records when precision-time-protocol event frames arrive. A frame parser raises a one-cycle strobe with the frame's message-type code, its source identity and its sequence identifier. The block checks the code against the node's role. A slave takes its capture from Sync frames, and a master takes its capture from Delay_Req frames. On a match, the current value of the 64-bit free-running system time is stored together with the frame's identity fields as one entry in a 16-deep FIFO.

Software works through a 16-bit register port. Reads are combinational and have no side effects. The head entry is shown as a set of word windows, and an event bit reports whether any entry is pending. Writing a one to the event bit releases the head entry. The bit then stays set for as long as entries remain, so software repeats read-and-release until the bit reads zero.

Top module: `ptp_rx_snap_fifo`

## Requirements
- R1: A capture occurs only on a cycle with `frame_valid_i` high. When `master_mode_i` is 0, the message code must be 4'h0 (Sync). When `master_mode_i` is 1, the code must be 4'h1 (Delay_Req). Every other code, and every strobe-less cycle, stores nothing.
- R2: A captured entry holds the `sys_time_i`, `src_id_i` and `seq_id_i` values present in the capture cycle. The entry is visible on the register port from the next cycle onward.
- R3: The FIFO holds up to 16 entries, which are released in arrival order.
- R4: A qualifying frame that arrives when the FIFO is full, with no release in the same cycle, is dropped entirely. No part of its time, source or sequence is kept.
- R5: Addresses 1, 2, 3 and 4 return head time bits [15:0], [31:16], [47:32] and [63:48]. Reads of any address, in any order, never change state.
- R6: Address 0 bit 0 is the event bit, which reads 1 exactly when the FIFO holds at least one entry. Bits 15:1 read 0.
- R7: A write to address 0 with data bit 0 set releases exactly one head entry. From the next cycle the windows show the following entry.
- R8: Addresses 5, 6 and 7 return the head source ID words from low to high. Address 8 returns the head sequence ID.
- R9: When the FIFO is empty, addresses 1 to 8 read 0. Addresses 9 to 15 always read 0.
- R10: A capture and a release in the same cycle both take effect, including when the FIFO is full, so the count is unchanged. A release while empty is ignored, and a capture in that cycle still stores its entry.
- R11: Reset empties the FIFO. A write to address 0 with bit 0 clear, and any write to another address, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sys_time_i | input | 64 | Free-running system time |
| frame_valid_i | input | 1 | One-cycle strobe for a received event frame |
| msg_type_i | input | 4 | Message-type code of that frame |
| src_id_i | input | 48 | Source identity of that frame |
| seq_id_i | input | 16 | Sequence identifier of that frame |
| master_mode_i | input | 1 | 1 = master role, 0 = slave role |
| reg_addr_i | input | 4 | Register word address for read and write |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Combinational register read data |

## Verification
The assertions assume the following about the inputs:
- The reset is released synchronously.
- The address, the write strobe and the frame strobe are free of X after reset.
- The release and capture decisions are taken from the values present at each rising edge.

The bench changes every input only at the falling edge and holds `sys_time_i` as a strictly increasing counter. The message code, mode, frame strobe and release writes are mixed freely, including the cases that drive the FIFO to full and to empty with both actions in the same cycle. Because of this, every one of the corner cases above is reached while the assumptions still hold.

// File: rtl/ptp_snap_pkg.sv
package ptp_snap_pkg;
  localparam int TIME_W = 64;
  localparam int SRC_W  = 48;
  localparam int SEQ_W  = 16;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;

  localparam int TS_WORDS  = TIME_W / REG_W;
  localparam int SRC_WORDS = SRC_W / REG_W;

  localparam logic [3:0] MSG_SYNC      = 4'h0;
  localparam logic [3:0] MSG_DELAY_REQ = 4'h1;

  localparam int ADDR_EVENT = 0;
  localparam int ADDR_TIME0 = 1;
  localparam int ADDR_SRC0  = ADDR_TIME0 + TS_WORDS;
  localparam int ADDR_SEQ   = ADDR_SRC0 + SRC_WORDS;

  typedef struct packed {
    logic [TIME_W-1:0] ts;
    logic [SRC_W-1:0]  src;
    logic [SEQ_W-1:0]  seq;
  } snap_entry_t;
endpackage

// File: rtl/ptp_snap_qualify.sv
module ptp_snap_qualify
  import ptp_snap_pkg::*;
(
  input  logic       frame_valid_i,
  input  logic [3:0] msg_type_i,
  input  logic       master_mode_i,
  output logic       capture_o
);
  logic [3:0] want_type;

  always_comb begin
    want_type = master_mode_i ? MSG_DELAY_REQ : MSG_SYNC;
    capture_o = frame_valid_i && (msg_type_i == want_type);
  end
endmodule

// File: rtl/ptp_snap_store.sv
module ptp_snap_store
  import ptp_snap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  snap_entry_t wdata_i,
  input  logic        pop_i,
  output snap_entry_t head_o,
  output logic        nonempty_o
);
  snap_entry_t     mem_q [DEPTH];
  logic [AW-1:0]   wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]   count_q;
  logic            full, pop_eff, push_eff;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full     = (count_q == CW'(DEPTH));
    pop_eff  = pop_i && (count_q != '0);
    // a release in the same cycle frees the slot the capture needs
    push_eff = push_i && (!full || pop_eff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_eff) wr_ptr_q <= next_ptr(wr_ptr_q);
      if (pop_eff)  rd_ptr_q <= next_ptr(rd_ptr_q);
      if (push_eff && !pop_eff)      count_q <= count_q + 1'b1;
      else if (pop_eff && !push_eff) count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_eff) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign head_o     = mem_q[rd_ptr_q];
  assign nonempty_o = (count_q != '0);

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  a_r4_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i) |=> (count_q == CW'(DEPTH)) && $stable(wr_ptr_q));

  a_r7_pop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

  a_r10_both_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && count_q != '0) |=> $stable(count_q));

  a_r10_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && pop_i && !push_i) |=> count_q == '0);
endmodule

// File: rtl/ptp_snap_regs.sv
module ptp_snap_regs
  import ptp_snap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  snap_entry_t       head_i,
  input  logic              nonempty_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              ack_o
);
  assign ack_o = we_i && (addr_i == ADDR_W'(ADDR_EVENT)) && wdata_i[0];

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_EVENT)) begin
      rdata_o[0] = nonempty_i;
    end else if (nonempty_i) begin
      for (int k = 0; k < TS_WORDS; k++)
        if (addr_i == ADDR_W'(ADDR_TIME0 + k)) rdata_o = head_i.ts[k*REG_W +: REG_W];
      for (int k = 0; k < SRC_WORDS; k++)
        if (addr_i == ADDR_W'(ADDR_SRC0 + k)) rdata_o = head_i.src[k*REG_W +: REG_W];
      if (addr_i == ADDR_W'(ADDR_SEQ)) rdata_o = head_i.seq;
    end
  end

  a_r9_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nonempty_i && addr_i != ADDR_W'(ADDR_EVENT)) |-> rdata_o == '0);

  a_r6_event_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(ADDR_EVENT)) |-> rdata_o[REG_W-1:1] == '0);
endmodule

// File: rtl/ptp_rx_snap_fifo.sv
module ptp_rx_snap_fifo
  import ptp_snap_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] sys_time_i,
  input  logic              frame_valid_i,
  input  logic [3:0]        msg_type_i,
  input  logic [SRC_W-1:0]  src_id_i,
  input  logic [SEQ_W-1:0]  seq_id_i,
  input  logic              master_mode_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o
);
  logic        capture, ack, nonempty;
  snap_entry_t new_entry, head;

  assign new_entry = '{ts: sys_time_i, src: src_id_i, seq: seq_id_i};

  ptp_snap_qualify u_qualify (
    .frame_valid_i (frame_valid_i),
    .msg_type_i    (msg_type_i),
    .master_mode_i (master_mode_i),
    .capture_o     (capture)
  );

  ptp_snap_store #(.DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (capture),
    .wdata_i    (new_entry),
    .pop_i      (ack),
    .head_o     (head),
    .nonempty_o (nonempty)
  );

  ptp_snap_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (reg_addr_i),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .head_i     (head),
    .nonempty_i (nonempty),
    .rdata_o    (reg_rdata_o),
    .ack_o      (ack)
  );

  a_r1_no_capture_off_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nonempty && !(frame_valid_i &&
      msg_type_i == (master_mode_i ? MSG_DELAY_REQ : MSG_SYNC))) |=> !nonempty);

  a_r11_idle_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture && !ack) |=> $stable(nonempty) && $stable(head));

  a_r2_capture_sets_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |=> nonempty);
endmodule

// File: tb/ptp_rx_snap_fifo_tb_top.sv
`timescale 1ns/1ps
module ptp_rx_snap_fifo_tb_top;
  localparam int DEPTH = 16;

  typedef struct packed {
    logic [63:0] ts;
    logic [47:0] src;
    logic [15:0] seq;
  } ref_entry_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] sys_time = 64'h1234_5678_9ABC_0000;
  logic        fv = 0;
  logic [3:0]  msg = 0;
  logic [47:0] src = 0;
  logic [15:0] seq = 0;
  logic        mode = 0;
  logic [3:0]  addr = 0;
  logic        we = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;

  int vectors = 0;
  int miscompares = 0;
  logic [15:0] last_rd;
  ref_entry_t model_q[$];

  always #4 clk = ~clk;

  ptp_rx_snap_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sys_time_i(sys_time), .frame_valid_i(fv),
    .msg_type_i(msg), .src_id_i(src), .seq_id_i(seq), .master_mode_i(mode),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s addr=%0d actual=%h expected=%h t=%0t", tag, addr, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [3:0] a);
    ref_entry_t h;
    if (a == 0) return {15'b0, model_q.size() != 0};
    if (model_q.size() == 0) return 16'h0;
    h = model_q[0];
    case (a)
      1: return h.ts[15:0];
      2: return h.ts[31:16];
      3: return h.ts[47:32];
      4: return h.ts[63:48];
      5: return h.src[15:0];
      6: return h.src[31:16];
      7: return h.src[47:32];
      8: return h.seq;
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    if (a == 0) return "R6";
    if (model_q.size() == 0 || a > 8) return "R9";
    if (a <= 4) return "R5";
    if (a <= 7) return "R8";
    return "R2";
  endfunction

  // one clock: drive at negedge, compare combinational read, then advance model at posedge
  task automatic cyc(input logic f, input logic [3:0] m, input logic md,
                     input logic w, input logic [3:0] a, input logic [15:0] wd);
    logic trig, ack;
    ref_entry_t e;
    @(negedge clk);
    fv = f; msg = m; mode = md; we = w; addr = a; wdata = wd;
    src = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
    seq = 16'($urandom());
    sys_time = sys_time + 64'h0001_0003_0007_000B;
    #1;
    last_rd = rdata;
    chk(rdata, model_read(a), tag_of(a));
    e = '{ts: sys_time, src: src, seq: seq};
    trig = f && (m == (md ? 4'h1 : 4'h0));
    ack = w && a == 0 && wd[0] && model_q.size() != 0;
    @(posedge clk);
    if (trig && (model_q.size() < DEPTH || ack)) begin
      if (ack) void'(model_q.pop_front());
      model_q.push_back(e);
    end else if (ack) begin
      void'(model_q.pop_front());
    end
  endtask

  task automatic idle_read(input logic [3:0] a);
    cyc(0, 0, mode, 0, a, 0);
  endtask

  task automatic read_all();
    for (int a = 0; a < 16; a++) idle_read(4'(a));
  endtask

  task automatic drain(output int n);
    n = 0;
    for (int i = 0; i < DEPTH + 4; i++) begin
      idle_read(0);
      if (last_rd[0] !== 1'b1) break;
      for (int a = 1; a <= 8; a++) idle_read(4'(a));
      cyc(0, 0, mode, 1, 0, 16'h0001);
      n++;
    end
  endtask

  initial begin
    #(200000 * 8);
    miscompares++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state: every address reads its empty value
    read_all();

    // R1: wrong type per role stores nothing
    cyc(1, 4'h1, 0, 0, 0, 0);
    cyc(1, 4'h2, 0, 0, 0, 0);
    cyc(1, 4'h0, 1, 0, 0, 0);
    cyc(1, 4'h8, 1, 0, 0, 0);
    cyc(0, 4'h0, 0, 0, 0, 0);
    idle_read(0);
    chk(last_rd, 16'h0000, "R1 no capture");

    // R2 master Delay_Req captured and shown next cycle
    cyc(1, 4'h1, 1, 0, 0, 0);
    read_all();
    idle_read(0);
    chk(last_rd, 16'h0001, "R2 event after capture");
    // R11 write of 0 and writes elsewhere do nothing
    cyc(0, 0, 1, 1, 0, 16'hFFFE);
    cyc(0, 0, 1, 1, 5, 16'hFFFF);
    idle_read(0);
    chk(last_rd, 16'h0001, "R11 write zero no effect");
    drain(n);
    chk(16'(n), 16'd1, "R7 single release");

    // R3/R4: fill past depth in slave mode
    for (int i = 0; i < DEPTH + 3; i++) cyc(1, 4'h0, 0, 0, 4'(i % 9), 0);
    read_all();
    drain(n);
    chk(16'(n), 16'(DEPTH), "R3 R4 depth and drop");

    // R10: full with simultaneous capture and release
    for (int i = 0; i < DEPTH; i++) cyc(1, 4'h0, 0, 0, 1, 0);
    cyc(1, 4'h0, 0, 1, 0, 16'h0001);
    read_all();
    drain(n);
    chk(16'(n), 16'(DEPTH), "R10 full push+pop keeps count");
    // R10: release on empty plus capture
    cyc(1, 4'h0, 0, 1, 0, 16'h0001);
    idle_read(0);
    chk(last_rd, 16'h0001, "R10 empty release ignored, capture kept");
    drain(n);
    chk(16'(n), 16'd1, "R10 one entry");

    // mixed random traffic covering R1..R11
    for (int i = 0; i < 4000; i++) begin
      logic f, w, md;
      logic [3:0] m;
      f  = ($urandom_range(0, 99) < 35);
      m  = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'($urandom_range(0, 1));
      md = (i / 500) % 2 == 1;
      w  = ($urandom_range(0, 99) < 25);
      cyc(f, m, md, w, 4'($urandom_range(0, 15)),
          ($urandom_range(0, 3) == 0) ? 16'h0000 : 16'($urandom()) | 16'h0001);
    end
    drain(n);
    idle_read(0);
    chk(last_rd, 16'h0000, "R7 final drain empty");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule